// File: doc/BRIEF.md
# Address-Masked GPIO Port Controller

This block is an eight-line general-purpose I/O port that sits behind an APB-style slave. It holds a per-pin direction register and a per-pin output value register. It also carries the pad inputs through a two-flop synchroniser. Each pin's output enable and output value come straight from those registers.

The data register is reached through a whole window of addresses rather than one location. Address bits [9:2] of any access into that window form a per-pin mask. Pin n is qualified by address bit n+2. A masked write changes only the selected pins, and a masked read returns zero for the pins that are not selected. Firmware can therefore set or clear one pin with a single store, and no read-modify-write sequence is needed.

Top module: `gmp_port`

## Requirements
- R1: After reset every pin is an input and every output value is 0, so pad_oe and pad_out are both 0x00.
- R2: A write whose address has bits [11:10] equal to 00 is a data access. Pin n takes pwdata[n] only when paddr[n+2] is 1. Every other pin keeps its output value.
- R3: On a data-window read, each pin whose mask bit paddr[n+2] is 0 reads back as 0, whatever the pin's level.
- R4: On a data-window read, each selected pin returns its driven output value when its direction bit is 1. It returns its synchronised pad value when its direction bit is 0.
- R5: The direction register sits at address 0x400. A 1 makes a pin an output and a 0 makes it an input. pad_oe equals the register, and a read of 0x400 returns it.
- R6: A change on pad_in appears on pin_sync and on data reads two clock edges later, and not before.
- R7: Any address outside the data window and other than 0x400 reads as 0. A write to such an address changes neither register.
- R8: pready is always 1 and pslverr is always 0.
- R9: A write takes effect only in the access phase, when psel, penable and pwrite are all 1. A setup phase alone changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address; bits [9:2] form the pin mask in the data window |
| pwdata | input | 8 | Write data |
| prdata | output | 8 | Read data, valid while psel is high and pwrite is low |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| pad_in | input | 8 | Raw pad levels |
| pad_oe | output | 8 | Per-pin output enable |
| pad_out | output | 8 | Per-pin output value |
| pin_sync | output | 8 | Synchronised copy of pad_in |

## Verification
The masked data path is driven with complementary nibble masks, an all-zero mask, a full mask and sparse masks that straddle both ends of the byte. These patterns separate a correct per-bit mask from a dropped, shifted or inverted one. A mixed direction setting with differing pad and output values shows whether a read picks the driven value or the pad value per pin. A pad step timed against clock edges fixes the synchroniser latency at exactly two. Stray offsets, setup-only writes and a long random mix of accesses are each compared against a behavioural model on every cycle.

// File: rtl/gmp_pkg.sv
package gmp_pkg;
   // Kind of register an address selects
   typedef enum logic [1:0] {
      ACC_NONE = 2'd0,
      ACC_DATA = 2'd1,
      ACC_DIR  = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/gmp_decode.sv
module gmp_decode
   import gmp_pkg::*;
#(
   parameter int PINS     = 8,
   parameter int ADDR_W   = 12,
   parameter int MASK_LSB = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output acc_kind_e         kind,
   output logic [PINS-1:0]   mask
);
   localparam int WIN_MSB = MASK_LSB + PINS;
   localparam logic [ADDR_W-1:0] DIR_ADDR = ADDR_W'(1) << WIN_MSB;

   generate
      if (ADDR_W <= WIN_MSB) begin : g_bad_addr
         $error("gmp_decode: ADDR_W too small for mask window");
      end
      if (MASK_LSB < 1) begin : g_bad_lsb
         $error("gmp_decode: MASK_LSB must be at least 1");
      end
   endgenerate

   assign mask = addr[MASK_LSB +: PINS];

   always_comb begin
      if (addr[ADDR_W-1:WIN_MSB] == '0)
         kind = ACC_DATA;
      else if (addr == DIR_ADDR)
         kind = ACC_DIR;
      else
         kind = ACC_NONE;
   end
endmodule

// File: rtl/gmp_sync.sv
module gmp_sync #(
   parameter int PINS   = 8,
   parameter int STAGES = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PINS-1:0] d,
   output logic [PINS-1:0] q
);
   generate
      if (STAGES < 2 || STAGES > 4) begin : g_bad_stages
         $error("gmp_sync: STAGES must be 2..4");
      end
   endgenerate

   logic [STAGES-1:0][PINS-1:0] chain;
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= '0;
      else        chain[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
         // R6: each stage carries the previous stage one edge later
         a_r6_stage_shift: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> chain[s] == $past(chain[s-1]));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R6: first stage captures the pad one edge later
   a_r6_first_stage: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> chain[0] == $past(d));

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gmp_regs.sv
module gmp_regs
   import gmp_pkg::*;
#(
   parameter int PINS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  acc_kind_e       kind,
   input  logic [PINS-1:0] mask,
   input  logic [PINS-1:0] wdata,
   output logic [PINS-1:0] dir_q,
   output logic [PINS-1:0] dout_q
);
   logic wr_data, wr_dir;
   assign wr_data = wr_en && (kind == ACC_DATA);
   assign wr_dir  = wr_en && (kind == ACC_DIR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (wr_dir) dir_q <= wdata;
   end

   generate
      for (genvar i = 0; i < PINS; i++) begin : g_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                  dout_q[i] <= 1'b0;
            else if (wr_data && mask[i]) dout_q[i] <= wdata[i];
         end
      end
   endgenerate

   // R2: unselected pins hold their value across a data write
   a_r2_unmasked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> ((dout_q ^ $past(dout_q)) & ~$past(mask)) == '0);
   // R2: selected pins take the written value
   a_r2_masked_take: assert property (@(posedge clk) disable iff (!rst_n)
      wr_data |=> ((dout_q ^ $past(wdata)) & $past(mask)) == '0);
   // R5: direction only moves on a direction write
   a_r5_dir_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dir |=> $stable(dir_q));
   // R7: writes to unmapped offsets touch nothing
   a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && kind == ACC_NONE) |=> ($stable(dir_q) && $stable(dout_q)));
endmodule

// File: rtl/gmp_rdmux.sv
module gmp_rdmux
   import gmp_pkg::*;
#(
   parameter int PINS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rd_en,
   input  acc_kind_e       kind,
   input  logic [PINS-1:0] mask,
   input  logic [PINS-1:0] dir_q,
   input  logic [PINS-1:0] dout_q,
   input  logic [PINS-1:0] pins,
   output logic [PINS-1:0] rdata
);
   logic [PINS-1:0] view;

   generate
      for (genvar i = 0; i < PINS; i++) begin : g_view
         assign view[i] = mask[i] & (dir_q[i] ? dout_q[i] : pins[i]);
      end
   endgenerate

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         unique case (kind)
            ACC_DATA: rdata = view;
            ACC_DIR:  rdata = dir_q;
            default:  rdata = '0;
         endcase
      end
   end

   // R3: unselected pins read as zero
   a_r3_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && kind == ACC_DATA) |-> (rdata & ~mask) == '0);
   // R7: unmapped offsets read as zero
   a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && kind == ACC_NONE) |-> rdata == '0);
endmodule

// File: rtl/gmp_port.sv
module gmp_port
   import gmp_pkg::*;
#(
   parameter int PINS     = 8,
   parameter int ADDR_W   = 12,
   parameter int MASK_LSB = 2,
   parameter int SYNC_LEN = 2
) (
   input  logic              pclk,
   input  logic              presetn,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [PINS-1:0]   pwdata,
   output logic [PINS-1:0]   prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic [PINS-1:0]   pad_in,
   output logic [PINS-1:0]   pad_oe,
   output logic [PINS-1:0]   pad_out,
   output logic [PINS-1:0]   pin_sync
);
   acc_kind_e       kind;
   logic [PINS-1:0] mask, dir_q, dout_q;
   logic            wr_en, rd_en;

   assign wr_en = psel & penable & pwrite;
   assign rd_en = psel & ~pwrite;

   gmp_decode #(.PINS(PINS), .ADDR_W(ADDR_W), .MASK_LSB(MASK_LSB)) u_decode (
      .addr (paddr),
      .kind (kind),
      .mask (mask)
   );

   gmp_regs #(.PINS(PINS)) u_regs (
      .clk    (pclk),
      .rst_n  (presetn),
      .wr_en  (wr_en),
      .kind   (kind),
      .mask   (mask),
      .wdata  (pwdata),
      .dir_q  (dir_q),
      .dout_q (dout_q)
   );

   gmp_sync #(.PINS(PINS), .STAGES(SYNC_LEN)) u_sync (
      .clk   (pclk),
      .rst_n (presetn),
      .d     (pad_in),
      .q     (pin_sync)
   );

   gmp_rdmux #(.PINS(PINS)) u_rdmux (
      .clk    (pclk),
      .rst_n  (presetn),
      .rd_en  (rd_en),
      .kind   (kind),
      .mask   (mask),
      .dir_q  (dir_q),
      .dout_q (dout_q),
      .pins   (pin_sync),
      .rdata  (prdata)
   );

   assign pad_oe  = dir_q;
   assign pad_out = dout_q;
   assign pready  = 1'b1;
   assign pslverr = 1'b0;

   // R4: selected output pins read back the driven value
   a_r4_out_readback: assert property (@(posedge pclk) disable iff (!presetn)
      (rd_en && kind == ACC_DATA) |-> ((prdata ^ pad_out) & mask & pad_oe) == '0);
   // R4: selected input pins read back the synchronised pad
   a_r4_in_readback: assert property (@(posedge pclk) disable iff (!presetn)
      (rd_en && kind == ACC_DATA) |-> ((prdata ^ pin_sync) & mask & ~pad_oe) == '0);
endmodule

// File: tb/test_gmp_port.sv
`timescale 1ns/1ps
module test_gmp_port;
   logic       pclk = 1'b0;
   logic       presetn = 1'b0;
   logic       psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [7:0] pwdata = '0, pad_in = '0;
   logic [7:0] prdata, pad_oe, pad_out, pin_sync;
   logic       pready, pslverr;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   always #5 pclk = ~pclk;

   gmp_port i_gmp_port (
      .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
      .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
      .pready(pready), .pslverr(pslverr), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .pin_sync(pin_sync)
   );

   // behavioural reference model
   logic [7:0] m_dir, m_dout;
   logic [7:0] m_pipe[$];

   always @(posedge pclk or negedge presetn) begin
      if (!presetn) begin
         m_dir  = 8'h00;
         m_dout = 8'h00;
         m_pipe = '{8'h00, 8'h00};
      end else begin
         if (psel && penable && pwrite) begin
            if (paddr[11:10] == 2'b00)
               m_dout = (m_dout & ~paddr[9:2]) | (pwdata & paddr[9:2]);
            else if (paddr == 12'h400)
               m_dir = pwdata;
         end
         m_pipe.push_back(pad_in);
         void'(m_pipe.pop_front());
      end
   end

   function automatic logic [7:0] model_rd();
      logic [7:0] v;
      v = 8'h00;
      if (psel && !pwrite) begin
         if (paddr[11:10] == 2'b00)
            v = paddr[9:2] & ((m_dir & m_dout) | (~m_dir & m_pipe[0]));
         else if (paddr == 12'h400)
            v = m_dir;
      end
      return v;
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge pclk) begin
      if (presetn) begin
         chk(cur_req, "prdata", prdata, model_rd());
         chk(cur_req, "pad_oe", pad_oe, m_dir);
         chk(cur_req, "pad_out", pad_out, m_dout);
         chk("R6", "pin_sync", pin_sync, m_pipe[0]);
         chk("R8", "pready/pslverr", {6'd0, pready, pslverr}, 8'h02);
      end
   end

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(posedge pclk); #2;
      end
   endtask

   task automatic apb_wr(input logic [11:0] a, input logic [7:0] d);
      @(posedge pclk); #2;
      psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
      @(posedge pclk); #2;
      penable = 1;
      @(posedge pclk); #2;
      psel = 0; penable = 0; pwrite = 0;
   endtask

   task automatic apb_rd(input logic [11:0] a, input logic [7:0] exp, input string req);
      @(posedge pclk); #2;
      psel = 1; pwrite = 0; penable = 0; paddr = a;
      @(posedge pclk); #2;
      penable = 1;
      @(negedge pclk);
      chk(req, "read", prdata, exp);
      @(posedge pclk); #2;
      psel = 0; penable = 0;
   endtask

   initial begin : watchdog
      #2_000_000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(posedge pclk);
      #2 presetn = 1;
      @(negedge pclk);
      chk("R1", "pad_oe after reset", pad_oe, 8'h00);
      chk("R1", "pad_out after reset", pad_out, 8'h00);

      cur_req = "R5";
      apb_wr(12'h400, 8'hFF);
      @(negedge pclk);
      chk("R5", "pad_oe all out", pad_oe, 8'hFF);
      apb_rd(12'h400, 8'hFF, "R5");

      cur_req = "R2";
      apb_wr(12'h03C, 8'hAA);          // mask 0x0F
      @(negedge pclk);
      chk("R2", "low nibble write", pad_out, 8'h0A);
      apb_wr(12'h3C0, 8'h55);          // mask 0xF0
      @(negedge pclk);
      chk("R2", "high nibble write", pad_out, 8'h5A);
      apb_wr(12'h000, 8'hFF);          // mask 0x00
      @(negedge pclk);
      chk("R2", "empty mask write", pad_out, 8'h5A);

      cur_req = "R3";
      apb_rd(12'h3FC, 8'h5A, "R3");
      apb_rd(12'h204, 8'h00, "R3");    // mask 0x81
      apb_rd(12'h028, 8'h0A, "R3");    // mask 0x0A

      cur_req = "R4";
      apb_wr(12'h400, 8'h0F);
      pad_in = 8'hC3;
      idle(3);
      apb_rd(12'h3FC, 8'hCA, "R4");

      cur_req = "R6";
      @(posedge pclk); #2;
      pad_in = 8'h3C;
      @(negedge pclk);
      chk("R6", "no edge yet", pin_sync, 8'hC3);
      @(negedge pclk);
      chk("R6", "one edge", pin_sync, 8'hC3);
      @(negedge pclk);
      chk("R6", "two edges", pin_sync, 8'h3C);

      cur_req = "R7";
      apb_wr(12'h800, 8'hFF);
      apb_wr(12'h404, 8'hFF);
      @(negedge pclk);
      chk("R7", "dir after stray write", pad_oe, 8'h0F);
      chk("R7", "out after stray write", pad_out, 8'h5A);
      apb_rd(12'h800, 8'h00, "R7");
      apb_rd(12'h404, 8'h00, "R7");

      cur_req = "R9";
      @(posedge pclk); #2;
      psel = 1; pwrite = 1; penable = 0; paddr = 12'h3FC; pwdata = 8'h00;
      @(posedge pclk); #2;
      psel = 0; pwrite = 0;
      @(negedge pclk);
      chk("R9", "setup-only write", pad_out, 8'h5A);

      cur_req = "R2";
      for (int n = 0; n < 300; n++) begin
         int op;
         op = $urandom_range(0, 4);
         case (op)
            0: apb_wr({2'b00, 8'($urandom), 2'b00}, 8'($urandom));
            1: apb_wr(12'h400, 8'($urandom));
            2: apb_rd_free({2'b00, 8'($urandom), 2'($urandom)});
            3: apb_rd_free(12'($urandom));
            default: begin
               @(posedge pclk); #2;
               pad_in = 8'($urandom);
            end
         endcase
      end
      idle(2);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   // read whose value is judged by the per-cycle model comparison
   task automatic apb_rd_free(input logic [11:0] a);
      @(posedge pclk); #2;
      psel = 1; pwrite = 0; penable = 0; paddr = a;
      @(posedge pclk); #2;
      penable = 1;
      @(posedge pclk); #2;
      psel = 0; penable = 0;
   endtask
endmodule